// File: doc/BRIEF.md
# Display Memory Command Executor

This block sits behind the serial receiver of a segment display controller. It takes each received byte, together with a flag saying whether the byte is a command or display data, and carries out the operation. It owns two 32-word by 4-bit memories. The display memory holds the segment pattern, and the blink memory holds a per-segment blink mask. One 5-bit pointer addresses both memories. The block also keeps the settings that the display timing logic needs: the multiplex mode, the frame divider choice, display enable, blink enable and blink rate, the decoder-path select, and the transfer-control state that decides whether a chip-select release latches the display.

A data byte is spread over several consecutive memory words. The layout depends on the multiplex mode, and the pointer advances by the number of words written. Commands with a 4-bit immediate write, AND or OR one word of either memory and then step the pointer. Every memory update is a single-cycle read-modify-write.

The controller moves through four states:
- S_IDLE waits for a byte or a chip-select strobe.
- S_CMD executes one command in one cycle.
- S_DATA writes one word per cycle, one cycle per layout step.
- S_ACK raises the consumed acknowledge for one cycle.

The transitions are:
- S_IDLE→S_CMD on a valid command byte.
- S_IDLE→S_DATA on a valid data byte.
- S_CMD→S_ACK always.
- S_DATA→S_DATA while steps remain.
- S_DATA→S_ACK on the last step.
- S_ACK→S_IDLE always.

Chip-select strobes are honoured only in S_IDLE, and they take precedence over a byte strobe arriving in the same cycle. The downstream decoder's own logic is outside this block.

Top module: `dme_top`

## Requirements
- R1: After reset, every mode output is 0, the display, blink and decoder select are off, the pointer is 0, both memories read 0 and the transfer mode is normal.
- R2: Command 010abcde sets mode_hi=a, mux_sel=bc and frame_div=de. The mux_sel encoding is 00 four-way, 10 three-way, 11 two-way and 01 static.
- R3: Command 111ppppp loads the pointer with ppppp. Every pointer increment wraps from 31 to 0.
- R4: Commands 1101dddd, 1011dddd and 1001dddd respectively write, OR and AND dddd into the display word at the pointer, then increment the pointer.
- R5: Commands 1100dddd, 1010dddd and 1000dddd respectively write, OR and AND dddd into the blink word at the pointer, then increment the pointer.
- R6: Command 0x20 clears all display words and the pointer. Command 0x00 clears all blink words and the pointer.
- R7: In static mode, data bit i (i=0..3) goes to bit 0 of word ptr+i. Bits 1..3 of those words are kept, and the pointer advances by 4.
- R8: In two-way mode, data bit 2i goes to bit 0 and data bit 2i+1 goes to bit 1 of word ptr+i (i=0..3). Bits 2..3 are kept, and the pointer advances by 4.
- R9: In three-way mode, data bit j goes to bit j mod 3 of word ptr+j/3. Bit 2 of word ptr+2 becomes 0, bit 3 of all three words is kept, and the pointer advances by 3.
- R10: In four-way mode, data bit j goes to bit j mod 4 of word ptr+j/4, and the pointer advances by 2.
- R11: The following commands set the control outputs:
  - 0x11 sets disp_on and 0x10 clears it.
  - 0001101k sets blink_on with blink_rate=k, and 0x18 clears blink_on.
  - 0x15 sets dec_en and 0x14 clears it.
- R12: A cs_rise strobe gives a one-cycle latch_stb pulse. After command 0x38, the next cs_rise gives no pulse, and the following cs_fall leaves the pointer unchanged. Command 0x30 cancels a pending pause.
- R13: done is high for exactly one cycle. For a command it comes 2 cycles after the byte strobe. For a data byte it comes 1+N cycles after the byte strobe, where N is the word count of the layout.
- R14: Outside the pause case, a cs_fall strobe resets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_in | input | 8 | Received byte |
| is_cmd | input | 1 | 1 = command, 0 = display data |
| byte_vld | input | 1 | One-cycle strobe, byte_in valid (taken in S_IDLE) |
| cs_rise | input | 1 | Chip-select release strobe |
| cs_fall | input | 1 | Chip-select assert strobe |
| rd_addr | input | 5 | Read address for both memories |
| rd_disp | output | 4 | Display word at rd_addr |
| rd_blink | output | 4 | Blink word at rd_addr |
| cur_ptr | output | 5 | Current pointer |
| mux_sel | output | 2 | Multiplex mode |
| mode_hi | output | 1 | Upper mode bit |
| frame_div | output | 2 | Frame divider select |
| disp_on | output | 1 | Display enabled |
| blink_on | output | 1 | Blinking enabled |
| blink_rate | output | 1 | Blink rate select |
| dec_en | output | 1 | Decoder path selected |
| latch_stb | output | 1 | Pulse: copy display memory to the display latch |
| done | output | 1 | Byte consumed acknowledge |

## Verification
The hardest situation to reach is a data layout that straddles the pointer wrap, with partial-word masks, on words that already hold nonzero data. Only then does a wrong keep mask or a wrong wrap show up. The stimulus reaches it in three steps. Immediate write commands first preload words with all-ones. A pointer load then places the start at address 30 before a three-way byte, so the burst covers addresses 30, 31 and 0. A full sweep of both memories then compares every word with the reference model. The pause sequence also needs a precise order: load, pause, release, assert, release again. This order shows both the suppressed latch and the kept pointer.

// File: rtl/dme_pkg.sv
package dme_pkg;

    typedef enum logic [1:0] {
        MUX4 = 2'b00,
        STAT = 2'b01,
        MUX3 = 2'b10,
        MUX2 = 2'b11
    } mux_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CMD  = 2'd1,
        S_DATA = 2'd2,
        S_ACK  = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        OP_MASK = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_CLR  = 2'd3
    } memop_e;

    // number of memory words one data byte occupies
    function automatic logic [2:0] step_count(input mux_e m);
        unique case (m)
            STAT:    return 3'd4;
            MUX2:    return 3'd4;
            MUX3:    return 3'd3;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/dme_layout.sv
module dme_layout
    import dme_pkg::*;
#(
    parameter int BW = 8,
    parameter int W  = 4
) (
    input  mux_e          mode,
    input  logic [BW-1:0] byte_i,
    input  logic [1:0]    step,
    output logic [W-1:0]  val,
    output logic [W-1:0]  mask
);
    localparam int IW = $clog2(BW);

    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;

    always_comb begin
        lo_idx = IW'({step, 1'b0});
        hi_idx = IW'({step, 1'b1});
    end

    always_comb begin
        val  = '0;
        mask = '0;
        unique case (mode)
            STAT: begin
                val[0]  = byte_i[IW'(step)];
                mask    = W'(1);
            end
            MUX2: begin
                val[0]  = byte_i[lo_idx];
                val[1]  = byte_i[hi_idx];
                mask    = W'(3);
            end
            MUX3: begin
                mask = W'(7);
                unique case (step)
                    2'd0:    val = W'(byte_i[2:0]);
                    2'd1:    val = W'(byte_i[5:3]);
                    default: val = W'(byte_i[7:6]);
                endcase
            end
            MUX4: begin
                mask = '1;
                val  = step[0] ? byte_i[7:4] : byte_i[3:0];
            end
        endcase
    end

endmodule

// File: rtl/dme_mem.sv
module dme_mem
    import dme_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int W     = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  memop_e        op,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  wmask,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] cur_word;
    logic         any_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            unique case (op)
                OP_MASK: mem_q[addr] <= (mem_q[addr] & ~wmask) | (wdata & wmask);
                OP_AND:  mem_q[addr] <= mem_q[addr] & wdata;
                OP_OR:   mem_q[addr] <= mem_q[addr] | wdata;
                OP_CLR:  for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            endcase
        end
    end

    always_comb begin
        rd_data  = mem_q[rd_addr];
        cur_word = mem_q[addr];
        any_set  = 1'b0;
        for (int i = 0; i < DEPTH; i++) any_set = any_set | (|mem_q[i]);
    end

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_CLR) |=> !any_set);  // R6

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_MASK) |=>
        ((mem_q[$past(addr)] & ~$past(wmask)) == ($past(cur_word) & ~$past(wmask))));  // R7

endmodule

// File: rtl/dme_top.sv
module dme_top
    import dme_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int W     = 4,
    parameter int BW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] byte_in,
    input  logic          is_cmd,
    input  logic          byte_vld,
    input  logic          cs_rise,
    input  logic          cs_fall,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_disp,
    output logic [W-1:0]  rd_blink,
    output logic [AW-1:0] cur_ptr,
    output logic [1:0]    mux_sel,
    output logic          mode_hi,
    output logic [1:0]    frame_div,
    output logic          disp_on,
    output logic          blink_on,
    output logic          blink_rate,
    output logic          dec_en,
    output logic          latch_stb,
    output logic          done
);
    st_e           state, nstate;
    logic [BW-1:0] byte_q;
    logic [1:0]    step_q;
    logic [AW-1:0] ptr_q;
    mux_e          mux_q;
    logic          m2_q;
    logic [1:0]    fdiv_q;
    logic          on_q, bon_q, brate_q, dec_q;
    logic          pause_q, hold_q, latch_q;

    logic          d_we, b_we;
    memop_e        mop;
    logic [W-1:0]  mwdata, mwmask;
    logic [W-1:0]  lay_val, lay_mask;
    logic [1:0]    last_step;
    logic          cs_evt;
    logic          is_imm, is_ldp;

    always_comb begin
        cs_evt    = cs_rise | cs_fall;
        last_step = 2'(step_count(mux_q) - 3'd1);
        is_ldp    = (byte_q[7:5] == 3'b111);
        is_imm    = byte_q[7] && !is_ldp;
    end

    dme_layout #(.BW(BW), .W(W)) u_layout (
        .mode   (mux_q),
        .byte_i (byte_q),
        .step   (step_q),
        .val    (lay_val),
        .mask   (lay_mask)
    );

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: if (!cs_evt && byte_vld) nstate = is_cmd ? S_CMD : S_DATA;
            S_CMD:  nstate = S_ACK;
            S_DATA: if (step_q == last_step) nstate = S_ACK;
            S_ACK:  nstate = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // memory port control
    always_comb begin
        d_we   = 1'b0;
        b_we   = 1'b0;
        mop    = OP_MASK;
        mwdata = byte_q[W-1:0];
        mwmask = '1;
        unique case (state)
            S_CMD: begin
                if (is_imm) begin
                    d_we = byte_q[4];
                    b_we = !byte_q[4];
                    unique case (byte_q[6:5])
                        2'b10:   mop = OP_MASK;
                        2'b01:   mop = OP_OR;
                        default: mop = OP_AND;
                    endcase
                end else if (byte_q == 8'h20) begin
                    d_we = 1'b1;
                    mop  = OP_CLR;
                end else if (byte_q == 8'h00) begin
                    b_we = 1'b1;
                    mop  = OP_CLR;
                end
            end
            S_DATA: begin
                d_we   = 1'b1;
                mwdata = lay_val;
                mwmask = lay_mask;
            end
            default: ;
        endcase
    end

    // register outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q  <= '0;
            step_q  <= '0;
            ptr_q   <= '0;
            mux_q   <= MUX4;
            m2_q    <= 1'b0;
            fdiv_q  <= '0;
            on_q    <= 1'b0;
            bon_q   <= 1'b0;
            brate_q <= 1'b0;
            dec_q   <= 1'b0;
            pause_q <= 1'b0;
            hold_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            latch_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cs_rise) begin
                        latch_q <= !pause_q;
                        if (pause_q) begin
                            pause_q <= 1'b0;
                            hold_q  <= 1'b1;
                        end
                    end else if (cs_fall) begin
                        if (hold_q) hold_q <= 1'b0;
                        else        ptr_q  <= '0;
                    end else if (byte_vld) begin
                        byte_q <= byte_in;
                        step_q <= '0;
                    end
                end
                S_CMD: begin
                    if (is_ldp) begin
                        ptr_q <= byte_q[AW-1:0];
                    end else if (is_imm) begin
                        ptr_q <= ptr_q + AW'(1);
                    end else if (byte_q[7:5] == 3'b010) begin
                        m2_q   <= byte_q[4];
                        mux_q  <= mux_e'(byte_q[3:2]);
                        fdiv_q <= byte_q[1:0];
                    end else if (byte_q[7:1] == 7'b0001101) begin
                        bon_q   <= 1'b1;
                        brate_q <= byte_q[0];
                    end else begin
                        unique case (byte_q)
                            8'h20, 8'h00: ptr_q   <= '0;
                            8'h38:        pause_q <= 1'b1;
                            8'h30:        pause_q <= 1'b0;
                            8'h11:        on_q    <= 1'b1;
                            8'h10:        on_q    <= 1'b0;
                            8'h18:        bon_q   <= 1'b0;
                            8'h15:        dec_q   <= 1'b1;
                            8'h14:        dec_q   <= 1'b0;
                            default: ;
                        endcase
                    end
                end
                S_DATA: begin
                    ptr_q  <= ptr_q + AW'(1);
                    step_q <= step_q + 2'd1;
                end
                S_ACK: ;
            endcase
        end
    end

    dme_mem #(.DEPTH(DEPTH), .W(W)) u_disp (
        .clk(clk), .rst_n(rst_n), .we(d_we), .op(mop), .addr(ptr_q),
        .wdata(mwdata), .wmask(mwmask), .rd_addr(rd_addr), .rd_data(rd_disp)
    );

    dme_mem #(.DEPTH(DEPTH), .W(W)) u_blink (
        .clk(clk), .rst_n(rst_n), .we(b_we), .op(mop), .addr(ptr_q),
        .wdata(mwdata), .wmask(mwmask), .rd_addr(rd_addr), .rd_data(rd_blink)
    );

    always_comb begin
        cur_ptr    = ptr_q;
        mux_sel    = mux_q;
        mode_hi    = m2_q;
        frame_div  = fdiv_q;
        disp_on    = on_q;
        blink_on   = bon_q;
        blink_rate = brate_q;
        dec_en     = dec_q;
        latch_stb  = latch_q;
        done       = (state == S_ACK);
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R13

    AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |=> (cur_ptr == $past(cur_ptr) + AW'(1)));  // R7

    AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD && byte_q[7:5] == 3'b111) |=> (cur_ptr == $past(byte_q[AW-1:0])));  // R3

    AST_PAUSE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cs_rise && pause_q) |=> !latch_stb);  // R12

    AST_CS_FALL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cs_fall && !cs_rise && !hold_q) |=> (cur_ptr == '0));  // R14

endmodule

// File: tb/dme_top_tb.sv
module dme_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = '0;
    logic       is_cmd = 1'b0;
    logic       byte_vld = 1'b0;
    logic       cs_rise = 1'b0;
    logic       cs_fall = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [3:0] rd_disp, rd_blink;
    logic [4:0] cur_ptr;
    logic [1:0] mux_sel, frame_div;
    logic       mode_hi, disp_on, blink_on, blink_rate, dec_en, latch_stb, done;

    int errors = 0;
    int checks = 0;

    // reference model
    logic [3:0] ref_d [32];
    logic [3:0] ref_b [32];
    logic [4:0] rptr;
    logic [1:0] rmux;
    logic       rpause, rhold;

    // scoreboard
    logic [4:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dme_top u_dut (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .is_cmd(is_cmd),
        .byte_vld(byte_vld), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .rd_addr(rd_addr), .rd_disp(rd_disp), .rd_blink(rd_blink),
        .cur_ptr(cur_ptr), .mux_sel(mux_sel), .mode_hi(mode_hi),
        .frame_div(frame_div), .disp_on(disp_on), .blink_on(blink_on),
        .blink_rate(blink_rate), .dec_en(dec_en), .latch_stb(latch_stb),
        .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: each acknowledge pops the expected pointer
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R13 unexpected done", 1, 0);
            end else begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cur_ptr == e, t, cur_ptr, e);
            end
        end
    end

    task automatic model(input logic [7:0] b, input bit c);
        if (c) begin
            if (b[7:5] == 3'b111) rptr = b[4:0];
            else if (b[7]) begin
                logic [3:0] w;
                w = b[4] ? ref_d[rptr] : ref_b[rptr];
                case (b[6:5])
                    2'b10:   w = b[3:0];
                    2'b01:   w = w | b[3:0];
                    default: w = w & b[3:0];
                endcase
                if (b[4]) ref_d[rptr] = w; else ref_b[rptr] = w;
                rptr = rptr + 5'd1;
            end
            else if (b[7:5] == 3'b010) rmux = b[3:2];
            else if (b == 8'h20) begin for (int i = 0; i < 32; i++) ref_d[i] = 4'h0; rptr = 0; end
            else if (b == 8'h00) begin for (int i = 0; i < 32; i++) ref_b[i] = 4'h0; rptr = 0; end
            else if (b == 8'h38) rpause = 1'b1;
            else if (b == 8'h30) rpause = 1'b0;
        end else begin
            case (rmux)
                2'b01: begin
                    for (int i = 0; i < 4; i++) ref_d[5'(rptr + 5'(i))][0] = b[i];
                    rptr = rptr + 5'd4;
                end
                2'b11: begin
                    for (int i = 0; i < 4; i++) begin
                        ref_d[5'(rptr + 5'(i))][0] = b[2*i];
                        ref_d[5'(rptr + 5'(i))][1] = b[2*i+1];
                    end
                    rptr = rptr + 5'd4;
                end
                2'b10: begin
                    for (int j = 0; j < 8; j++) ref_d[5'(rptr + 5'(j/3))][j%3] = b[j];
                    ref_d[5'(rptr + 5'd2)][2] = 1'b0;
                    rptr = rptr + 5'd3;
                end
                default: begin
                    for (int j = 0; j < 8; j++) ref_d[5'(rptr + 5'(j/4))][j%4] = b[j];
                    rptr = rptr + 5'd2;
                end
            endcase
        end
    endtask

    task automatic send(input logic [7:0] b, input bit c, input int exp_lat, input string tag);
        int n;
        model(b, c);
        exp_q.push_back(rptr);
        tag_q.push_back(tag);
        @(negedge clk);
        byte_in = b; is_cmd = c; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        n = 1;
        while (!done) begin @(negedge clk); n++; end
        if (exp_lat > 0) chk(n == exp_lat, "R13 latency", n, exp_lat);
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        int bad = 0;
        int ba = 0, bx = 0;
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a);
            #1;
            if ((rd_disp !== ref_d[a] || rd_blink !== ref_b[a]) && bad == 0) begin
                bad = 1;
                ba = {rd_blink, rd_disp};
                bx = {ref_b[a], ref_d[a]};
                $display("  mismatch at word %0d", a);
            end
        end
        chk(bad == 0, tag, ba, bx);
    endtask

    task automatic pulse_rise(input bit exp_latch, input string tag);
        @(negedge clk); cs_rise = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
        chk(latch_stb == exp_latch, tag, latch_stb, exp_latch);
        @(negedge clk);
        chk(latch_stb == 1'b0, {tag, " pulse width"}, latch_stb, 0);
        if (rpause) begin rpause = 1'b0; rhold = 1'b1; end
    endtask

    task automatic pulse_fall(input string tag);
        @(negedge clk); cs_fall = 1'b1;
        @(negedge clk); cs_fall = 1'b0;
        if (rhold) rhold = 1'b0; else rptr = 5'd0;
        chk(cur_ptr == rptr, tag, cur_ptr, rptr);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin ref_d[i] = 4'h0; ref_b[i] = 4'h0; end
        rptr = 0; rmux = 0; rpause = 0; rhold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({mux_sel, mode_hi, frame_div} == 5'd0, "R1 mode regs", {mux_sel, mode_hi, frame_div}, 0);
        chk({disp_on, blink_on, blink_rate, dec_en, latch_stb, done} == 6'd0, "R1 flags",
            {disp_on, blink_on, blink_rate, dec_en, latch_stb, done}, 0);
        chk(cur_ptr == 5'd0, "R1 pointer", cur_ptr, 0);
        sweep("R1 memories clear");

        // R2 mode set
        send(8'h5B, 1'b1, 2, "R2 ptr");
        chk({mode_hi, mux_sel, frame_div} == 5'b1_10_11, "R2 fields", {mode_hi, mux_sel, frame_div}, 5'b11011);
        send(8'h45, 1'b1, 0, "R2 ptr");
        chk({mode_hi, mux_sel, frame_div} == 5'b0_01_01, "R2 static", {mode_hi, mux_sel, frame_div}, 5'b00101);

        // R3 pointer load and wrap, R4 display immediates
        send(8'hFE, 1'b1, 0, "R3 load 30");
        send(8'hD5, 1'b1, 0, "R4 write ptr");
        send(8'hDA, 1'b1, 0, "R3 wrap to 0");
        send(8'hDC, 1'b1, 0, "R4 write ptr");
        send(8'hE0, 1'b1, 0, "R3 load 0");
        send(8'hB3, 1'b1, 0, "R4 or ptr");
        send(8'h96, 1'b1, 0, "R4 and ptr");
        sweep("R4 display immediates");

        // R5 blink immediates
        send(8'hE4, 1'b1, 0, "R3 load 4");
        send(8'hC9, 1'b1, 0, "R5 write ptr");
        send(8'hE4, 1'b1, 0, "R3 load 4");
        send(8'hA6, 1'b1, 0, "R5 or ptr");
        send(8'hE4, 1'b1, 0, "R3 load 4");
        send(8'h85, 1'b1, 0, "R5 and ptr");
        sweep("R5 blink immediates");

        // R7 static layout on preloaded words
        send(8'hE8, 1'b1, 0, "R3 load 8");
        for (int i = 0; i < 4; i++) send(8'hDF, 1'b1, 0, "R4 preload");
        send(8'hE8, 1'b1, 0, "R3 load 8");
        send(8'hA6, 1'b0, 5, "R7 ptr +4");
        sweep("R7 static layout");

        // R8 two-way
        send(8'h4C, 1'b1, 0, "R2 ptr");
        send(8'h96, 1'b0, 5, "R8 ptr +4");
        sweep("R8 two-way layout");

        // R9 three-way across the wrap
        send(8'h48, 1'b1, 0, "R2 ptr");
        send(8'hFE, 1'b1, 0, "R3 load 30");
        for (int i = 0; i < 3; i++) send(8'hDF, 1'b1, 0, "R4 preload");
        send(8'hFE, 1'b1, 0, "R3 load 30");
        send(8'hFF, 1'b0, 4, "R9 ptr +3 wrap");
        sweep("R9 three-way layout");
        send(8'h5D, 1'b0, 4, "R9 ptr +3");
        sweep("R9 three-way second");

        // R10 four-way
        send(8'h40, 1'b1, 0, "R2 ptr");
        send(8'hA7, 1'b0, 3, "R10 ptr +2");
        send(8'h3C, 1'b0, 3, "R10 ptr +2");
        sweep("R10 four-way layout");

        // R6 clears
        send(8'hE9, 1'b1, 0, "R3 load 9");
        send(8'h20, 1'b1, 0, "R6 clear disp ptr");
        sweep("R6 display cleared");
        send(8'hE9, 1'b1, 0, "R3 load 9");
        send(8'h00, 1'b1, 0, "R6 clear blink ptr");
        sweep("R6 blink cleared");

        // R11 control commands
        send(8'h11, 1'b1, 0, "R11 ptr");
        chk(disp_on == 1'b1, "R11 display on", disp_on, 1);
        send(8'h1B, 1'b1, 0, "R11 ptr");
        chk({blink_on, blink_rate} == 2'b11, "R11 blink rate 1", {blink_on, blink_rate}, 3);
        send(8'h1A, 1'b1, 0, "R11 ptr");
        chk({blink_on, blink_rate} == 2'b10, "R11 blink rate 0", {blink_on, blink_rate}, 2);
        send(8'h15, 1'b1, 0, "R11 ptr");
        chk(dec_en == 1'b1, "R11 decoder on", dec_en, 1);
        send(8'h10, 1'b1, 0, "R11 ptr");
        send(8'h18, 1'b1, 0, "R11 ptr");
        send(8'h14, 1'b1, 0, "R11 ptr");
        chk({disp_on, blink_on, dec_en} == 3'b000, "R11 all off", {disp_on, blink_on, dec_en}, 0);

        // R12 / R14 transfer control
        send(8'hE5, 1'b1, 0, "R3 load 5");
        pulse_rise(1'b1, "R12 normal latch");
        pulse_fall("R14 fall clears ptr");
        send(8'hE9, 1'b1, 0, "R3 load 9");
        send(8'h38, 1'b1, 0, "R12 pause ptr");
        pulse_rise(1'b0, "R12 paused no latch");
        pulse_fall("R12 pointer kept");
        pulse_rise(1'b1, "R12 second rise latches");
        pulse_fall("R14 fall clears ptr");
        send(8'h38, 1'b1, 0, "R12 pause ptr");
        send(8'h30, 1'b1, 0, "R12 unsync ptr");
        pulse_rise(1'b1, "R12 unsync restores latch");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R13 all bytes acknowledged", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule